// File: doc/BRIEF.md
# Host Byte-to-Word Link Bridge

This block connects an 8-bit host I/O bus to a 32-bit word link port on an attached processor. The host sees three byte-wide registers. A control register drives the processor's reset and non-maskable interrupt lines. A status register reports whether each direction is ready. A data register is shared by both directions: host writes go to the transmit path and host reads come from the receive path.

On the transmit side, four byte writes are packed into one 32-bit word, least significant byte first. The word is then offered to the link with a valid/ready handshake. On the receive side, one word is accepted from the link with its own valid/ready pair and handed back as four byte reads, least significant byte first. Each direction has its own byte phase counter, so packing and unpacking can be interleaved. Each status flag covers a whole 4-byte burst, so the host needs to poll status only once per word.

The host bus is reduced to an address, write data, a read strobe, a write strobe and combinational read data. Each strobe is active for one clock cycle per access.

Top module: `hbl_bridge`

## Requirements
- R1: A write to address 0x30C loads the control register on the next clock edge. Bit 0 drives `cpu_reset` and bit 1 drives `cpu_nmi`. A read of 0x30C returns these two bits in positions 1:0 and zeros in positions 7:2.
- R2: A read of address 0x304 returns the status byte. Bit 7 is 1 when the transmit word is free, bit 6 is 1 when a received word is waiting, and bits 5:0 are 0.
- R3: Writes to address 0x30A fill the transmit word least significant byte first, so the first byte lands in bits 7:0 and the fourth in bits 31:24. `tx_valid` rises on the clock edge that takes the fourth byte, and `tx_word` then holds the packed word. Once status bit 7 reads 1, four data writes in a row are all accepted.
- R4: After the fourth write, status bit 7 reads 0. `tx_valid` stays high and `tx_word` stays unchanged until a cycle in which `tx_ready` is high. On the edge after that cycle, `tx_valid` falls and status bit 7 reads 1 again.
- R5: A data write made while the transmit word is full is ignored. The offered word does not change, and the next word still starts at byte 0.
- R6: `rx_ready` is high while no received word is held. A cycle with `rx_valid` and `rx_ready` both high captures `rx_word`. After that edge, `rx_ready` is low and status bit 6 reads 1.
- R7: Four reads of 0x30A return the held word least significant byte first. After the fourth read, status bit 6 reads 0 and `rx_ready` is high again.
- R8: A read of 0x30A while no received word is held returns 0x00 and does not advance the receive byte phase.
- R9: A read of any address other than the three above returns 0x00. A write to any other address changes no output and no register.
- R10: After reset, `cpu_reset`, `cpu_nmi` and `tx_valid` are 0, `rx_ready` is 1, the status byte is 0x80, and both byte phases start at 0.
- R11: The transmit and receive byte phases are independent. A complete receive word can be read out between two transmit bytes of one word, and the transmit word is still packed correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 10 | Host I/O address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_rdata | output | 8 | Host read data, valid in the same cycle as `host_rd` |
| tx_word | output | 32 | Packed word offered to the link |
| tx_valid | output | 1 | Packed word is being offered |
| tx_ready | input | 1 | Link takes the offered word |
| rx_word | input | 32 | Word offered by the link |
| rx_valid | input | 1 | Link word is being offered |
| rx_ready | output | 1 | Bridge can take a link word |
| cpu_reset | output | 1 | Holds the attached processor in reset |
| cpu_nmi | output | 1 | Non-maskable interrupt to the attached processor |

## Verification
Read data, including status and data bytes, is combinational. The bench samples it 1 ns after it drives the read strobe, within the same cycle. Every register effect of an access (control outputs, `tx_valid`, `tx_word`, byte-phase advance and the empty/full flags) appears one edge after the strobe. The bench drives all inputs on the falling edge and checks those outputs at the following falling edge. Handshake results follow the same rule: `tx_valid` falls and `rx_ready` falls one edge after the cycle in which the handshake completes, and they are checked at the falling edge after that.

// File: rtl/hbl_pkg.sv
package hbl_pkg;

   // Which host register an address selects
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTL  = 2'd1,
      SEL_STAT = 2'd2,
      SEL_PORT = 2'd3
   } hbl_sel_e;

   function automatic int unsigned hbl_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/hbl_decode.sv
module hbl_decode
   import hbl_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 10,
   parameter logic [ADDR_W-1:0] CTL_ADDR  = 10'h30C,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 10'h304,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 10'h30A
)(
   input  logic [ADDR_W-1:0] addr,
   output hbl_sel_e          sel
);

   if (CTL_ADDR == STAT_ADDR || CTL_ADDR == PORT_ADDR || STAT_ADDR == PORT_ADDR) begin : g_bad_map
      $error("hbl_decode: register addresses must differ");
   end

   always_comb begin
      if (addr == CTL_ADDR)       sel = SEL_CTL;
      else if (addr == STAT_ADDR) sel = SEL_STAT;
      else if (addr == PORT_ADDR) sel = SEL_PORT;
      else                        sel = SEL_NONE;
   end

endmodule

// File: rtl/hbl_ctl.sv
module hbl_ctl #(
   parameter int unsigned CTL_W   = 2,
   parameter int unsigned RST_BIT = 0,
   parameter int unsigned NMI_BIT = 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wdata,
   output logic [CTL_W-1:0] ctl_q,
   output logic             cpu_reset,
   output logic             cpu_nmi
);

   if (RST_BIT >= CTL_W || NMI_BIT >= CTL_W || RST_BIT == NMI_BIT) begin : g_bad_bits
      $error("hbl_ctl: control bit positions out of range or overlapping");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctl_q <= '0;
      else if (wr_en) ctl_q <= wdata;
   end

   assign cpu_reset = ctl_q[RST_BIT];
   assign cpu_nmi   = ctl_q[NMI_BIT];

endmodule

// File: rtl/hbl_pack.sv
module hbl_pack #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned LANES  = 4
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [BYTE_W-1:0]       wdata,
   input  logic                    tx_ready,
   output logic [LANES*BYTE_W-1:0] tx_word,
   output logic                    tx_valid
);

   localparam int unsigned CNT_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LANES - 1);

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("hbl_pack: LANES must be a power of two, at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             full_q;
   logic             take;

   // A byte is taken only while the holding word is free
   assign take = wr_en && !full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (take) cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    full_q <= 1'b0;
      else if (take && cnt_q == LAST) full_q <= 1'b1;
      else if (full_q && tx_ready)   full_q <= 1'b0;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam logic [CNT_W-1:0] IDX = CNT_W'(g);
      logic [BYTE_W-1:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   lane_q <= '0;
         else if (take && cnt_q == IDX) lane_q <= wdata;
      end
      assign tx_word[g*BYTE_W +: BYTE_W] = lane_q;
   end

   assign tx_valid = full_q;

endmodule

// File: rtl/hbl_unpack.sv
module hbl_unpack #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned LANES  = 4,
   parameter bit          SHIFT  = 1'b0
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES*BYTE_W-1:0] rx_word,
   input  logic                    rx_valid,
   output logic                    rx_ready,
   input  logic                    rd_en,
   output logic [BYTE_W-1:0]       byte_out,
   output logic                    full
);

   localparam int unsigned WORD_W = LANES * BYTE_W;
   localparam int unsigned CNT_W  = (LANES > 1) ? $clog2(LANES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LANES - 1);

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("hbl_unpack: LANES must be a power of two, at least 2");
   end

   logic [WORD_W-1:0] buf_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              full_q;
   logic              load;
   logic              pop;

   assign load = rx_valid && !full_q;
   assign pop  = rd_en && full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (pop) cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    full_q <= 1'b0;
      else if (load)                 full_q <= 1'b1;
      else if (pop && cnt_q == LAST) full_q <= 1'b0;
   end

   if (SHIFT) begin : g_shift
      // Word shifts down one byte per read; output is always the low lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    buf_q <= '0;
         else if (load) buf_q <= rx_word;
         else if (pop)  buf_q <= buf_q >> BYTE_W;
      end
      assign byte_out = buf_q[BYTE_W-1:0];
   end else begin : g_mux
      // Word stays put; the phase counter selects the lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    buf_q <= '0;
         else if (load) buf_q <= rx_word;
      end
      always_comb begin
         byte_out = '0;
         for (int k = 0; k < LANES; k++) begin
            if (cnt_q == CNT_W'(k)) byte_out = buf_q[k*BYTE_W +: BYTE_W];
         end
      end
   end

   assign rx_ready = !full_q;
   assign full     = full_q;

endmodule

// File: rtl/hbl_bridge.sv
module hbl_bridge
   import hbl_pkg::*;
#(
   parameter int unsigned       ADDR_W      = 10,
   parameter int unsigned       BYTE_W      = 8,
   parameter int unsigned       WORD_W      = 32,
   parameter logic [ADDR_W-1:0] CTL_ADDR    = 10'h30C,
   parameter logic [ADDR_W-1:0] STAT_ADDR   = 10'h304,
   parameter logic [ADDR_W-1:0] PORT_ADDR   = 10'h30A,
   parameter int unsigned       TXFREE_BIT  = 7,
   parameter int unsigned       RXAVAIL_BIT = 6,
   parameter int unsigned       RST_BIT     = 0,
   parameter int unsigned       NMI_BIT     = 1,
   parameter bit                RX_SHIFT    = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [BYTE_W-1:0] host_wdata,
   input  logic              host_wr,
   input  logic              host_rd,
   output logic [BYTE_W-1:0] host_rdata,
   output logic [WORD_W-1:0] tx_word,
   output logic              tx_valid,
   input  logic              tx_ready,
   input  logic [WORD_W-1:0] rx_word,
   input  logic              rx_valid,
   output logic              rx_ready,
   output logic              cpu_reset,
   output logic              cpu_nmi
);

   localparam int unsigned LANES = WORD_W / BYTE_W;
   localparam int unsigned CTL_W = hbl_max(RST_BIT, NMI_BIT) + 1;

   if (WORD_W % BYTE_W != 0) begin : g_bad_width
      $error("hbl_bridge: WORD_W must be a multiple of BYTE_W");
   end
   if (TXFREE_BIT >= BYTE_W || RXAVAIL_BIT >= BYTE_W || TXFREE_BIT == RXAVAIL_BIT) begin : g_bad_stat
      $error("hbl_bridge: status bit positions out of range or overlapping");
   end
   if (CTL_W > BYTE_W) begin : g_bad_ctl
      $error("hbl_bridge: control register wider than the host byte");
   end

   hbl_sel_e          sel;
   logic [CTL_W-1:0]  ctl_q;
   logic [BYTE_W-1:0] rx_byte;
   logic              rx_full;
   logic [BYTE_W-1:0] stat_byte;
   logic [BYTE_W-1:0] ctl_byte;

   hbl_decode #(
      .ADDR_W    (ADDR_W),
      .CTL_ADDR  (CTL_ADDR),
      .STAT_ADDR (STAT_ADDR),
      .PORT_ADDR (PORT_ADDR)
   ) u_decode (
      .addr (host_addr),
      .sel  (sel)
   );

   hbl_ctl #(
      .CTL_W   (CTL_W),
      .RST_BIT (RST_BIT),
      .NMI_BIT (NMI_BIT)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (host_wr && sel == SEL_CTL),
      .wdata     (host_wdata[CTL_W-1:0]),
      .ctl_q     (ctl_q),
      .cpu_reset (cpu_reset),
      .cpu_nmi   (cpu_nmi)
   );

   hbl_pack #(
      .BYTE_W (BYTE_W),
      .LANES  (LANES)
   ) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (host_wr && sel == SEL_PORT),
      .wdata    (host_wdata),
      .tx_ready (tx_ready),
      .tx_word  (tx_word),
      .tx_valid (tx_valid)
   );

   hbl_unpack #(
      .BYTE_W (BYTE_W),
      .LANES  (LANES),
      .SHIFT  (RX_SHIFT)
   ) u_unpack (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_word  (rx_word),
      .rx_valid (rx_valid),
      .rx_ready (rx_ready),
      .rd_en    (host_rd && sel == SEL_PORT),
      .byte_out (rx_byte),
      .full     (rx_full)
   );

   always_comb begin
      stat_byte              = '0;
      stat_byte[TXFREE_BIT]  = !tx_valid;
      stat_byte[RXAVAIL_BIT] = rx_full;
   end

   always_comb begin
      ctl_byte              = '0;
      ctl_byte[CTL_W-1:0]   = ctl_q;
   end

   always_comb begin
      host_rdata = '0;
      if (host_rd) begin
         unique case (sel)
            SEL_CTL:  host_rdata = ctl_byte;
            SEL_STAT: host_rdata = stat_byte;
            SEL_PORT: host_rdata = rx_full ? rx_byte : '0;
            default:  host_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/hbl_checker.sv
module hbl_checker #(
   parameter int unsigned       ADDR_W      = 10,
   parameter int unsigned       BYTE_W      = 8,
   parameter int unsigned       WORD_W      = 32,
   parameter logic [ADDR_W-1:0] CTL_ADDR    = 10'h30C,
   parameter logic [ADDR_W-1:0] STAT_ADDR   = 10'h304,
   parameter logic [ADDR_W-1:0] PORT_ADDR   = 10'h30A,
   parameter int unsigned       TXFREE_BIT  = 7,
   parameter int unsigned       RXAVAIL_BIT = 6
)(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] host_addr,
   input logic [1:0]        host_wdata_lo,
   input logic              host_wr,
   input logic              host_rd,
   input logic [BYTE_W-1:0] host_rdata,
   input logic [WORD_W-1:0] tx_word,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              cpu_reset,
   input logic              cpu_nmi
);

   logic ctl_hit;
   logic known;
   logic [BYTE_W-1:0] spare_mask;

   assign ctl_hit = host_wr && host_addr == CTL_ADDR;
   assign known   = host_addr == CTL_ADDR || host_addr == STAT_ADDR || host_addr == PORT_ADDR;

   always_comb begin
      spare_mask              = '1;
      spare_mask[TXFREE_BIT]  = 1'b0;
      spare_mask[RXAVAIL_BIT] = 1'b0;
   end

   AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_hit |=> (cpu_reset == $past(host_wdata_lo[0])) && (cpu_nmi == $past(host_wdata_lo[1]))); // R1

   AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_hit |=> $stable(cpu_reset) && $stable(cpu_nmi)); // R9

   AST_STAT_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == STAT_ADDR) |-> ((host_rdata & spare_mask) == '0)); // R2

   AST_STAT_TXFREE: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == STAT_ADDR) |-> (host_rdata[TXFREE_BIT] != tx_valid)); // R2

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_word)); // R4

   AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_valid); // R4

   AST_RX_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_ready) |=> !rx_ready); // R6

   AST_PORT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == PORT_ADDR && rx_ready) |-> host_rdata == '0); // R8

   AST_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !known) |-> host_rdata == '0); // R9

endmodule

bind hbl_bridge hbl_checker #(
   .ADDR_W      (ADDR_W),
   .BYTE_W      (BYTE_W),
   .WORD_W      (WORD_W),
   .CTL_ADDR    (CTL_ADDR),
   .STAT_ADDR   (STAT_ADDR),
   .PORT_ADDR   (PORT_ADDR),
   .TXFREE_BIT  (TXFREE_BIT),
   .RXAVAIL_BIT (RXAVAIL_BIT)
) u_hbl_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .host_addr     (host_addr),
   .host_wdata_lo (host_wdata[1:0]),
   .host_wr       (host_wr),
   .host_rd       (host_rd),
   .host_rdata    (host_rdata),
   .tx_word       (tx_word),
   .tx_valid      (tx_valid),
   .tx_ready      (tx_ready),
   .rx_valid      (rx_valid),
   .rx_ready      (rx_ready),
   .cpu_reset     (cpu_reset),
   .cpu_nmi       (cpu_nmi)
);

// File: tb/tb_hbl_bridge.sv
`timescale 1ns/1ps
module tb_hbl_bridge;

   localparam logic [9:0] A_CTL  = 10'h30C;
   localparam logic [9:0] A_STAT = 10'h304;
   localparam logic [9:0] A_PORT = 10'h30A;

   // Each entry: word sent host->link; its inverse is sent link->host
   localparam int NV = 6;
   localparam logic [31:0] VEC [NV] = '{
      32'h0000_0000, 32'hFFFF_FFFF, 32'h0403_0201,
      32'hA5C3_3C5A, 32'h8000_0001, 32'hDEAD_BEEF
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic       host_wr = 1'b0;
   logic       host_rd = 1'b0;
   logic [7:0] host_rdata;
   logic [31:0] tx_word;
   logic       tx_valid;
   logic       tx_ready = 1'b0;
   logic [31:0] rx_word = '0;
   logic       rx_valid = 1'b0;
   logic       rx_ready;
   logic       cpu_reset;
   logic       cpu_nmi;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   hbl_bridge dut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
      .tx_word(tx_word), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_word(rx_word), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .cpu_reset(cpu_reset), .cpu_nmi(cpu_nmi)
   );

   task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string what);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", what, got, exp);
      end
   endtask

   task automatic do_wr(input logic [9:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic do_rd(input logic [9:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic push_rx(input logic [31:0] w);
      @(negedge clk);
      rx_word = w; rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic pulse_ready;
      @(negedge clk);
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [7:0] b;
      logic [31:0] w;

      // Reset state
      repeat (3) @(negedge clk);
      chk({31'd0, cpu_reset}, 0, "R10 cpu_reset in reset");
      chk({31'd0, tx_valid}, 0, "R10 tx_valid in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk({31'd0, rx_ready}, 1, "R10 rx_ready after reset");
      chk({31'd0, cpu_nmi}, 0, "R10 cpu_nmi after reset");
      do_rd(A_STAT, b);
      chk({24'd0, b}, 32'h80, "R10 status after reset");

      // Table walk: transmit then receive one word per entry
      for (int i = 0; i < NV; i++) begin
         do_rd(A_STAT, b);
         chk({31'd0, b[7]}, 1, "R2 bit7 free before burst");
         for (int k = 0; k < 4; k++) begin
            do_wr(A_PORT, VEC[i][8*k +: 8]);
            if (k < 3) chk({31'd0, tx_valid}, 0, "R3 tx_valid before fourth byte");
         end
         chk({31'd0, tx_valid}, 1, "R3 tx_valid after fourth byte");
         chk(tx_word, VEC[i], "R3 packed word");
         do_rd(A_STAT, b);
         chk({24'd0, b}, 32'h00, "R4 status while full");
         if (i == 2) begin
            do_wr(A_PORT, 8'h77);
            chk(tx_word, VEC[i], "R5 write while full ignored");
         end
         repeat (3) @(negedge clk);
         chk(tx_word, VEC[i], "R4 word held without ready");
         chk({31'd0, tx_valid}, 1, "R4 valid held without ready");
         pulse_ready();
         chk({31'd0, tx_valid}, 0, "R4 valid drops after ready");
         do_rd(A_STAT, b);
         chk({24'd0, b}, 32'h80, "R4 status free after handshake");

         push_rx(~VEC[i]);
         chk({31'd0, rx_ready}, 0, "R6 rx_ready low after capture");
         do_rd(A_STAT, b);
         chk({24'd0, b}, 32'hC0, "R6 status word waiting");
         for (int k = 0; k < 4; k++) begin
            do_rd(A_PORT, b);
            w = ~VEC[i];
            chk({24'd0, b}, {24'd0, w[8*k +: 8]}, "R7 byte order");
         end
         chk({31'd0, rx_ready}, 1, "R7 rx_ready back high");
         do_rd(A_STAT, b);
         chk({24'd0, b}, 32'h80, "R7 status after four reads");
      end

      // R5: after ignored write, next word still starts at byte 0
      for (int k = 0; k < 4; k++) do_wr(A_PORT, 8'h10 + 8'(k));
      chk(tx_word, 32'h1312_1110, "R5 phase intact after ignored write");
      pulse_ready();

      // R1 control register
      do_wr(A_CTL, 8'h03);
      chk({30'd0, cpu_nmi, cpu_reset}, 3, "R1 both control lines set");
      do_rd(A_CTL, b);
      chk({24'd0, b}, 32'h03, "R1 control readback");
      do_wr(A_CTL, 8'hFE);
      chk({30'd0, cpu_nmi, cpu_reset}, 2, "R1 nmi only");
      do_rd(A_CTL, b);
      chk({24'd0, b}, 32'h02, "R1 spare control bits read 0");

      // R9 other addresses
      do_wr(10'h30B, 8'h55);
      do_wr(10'h308, 8'h01);
      chk({30'd0, cpu_nmi, cpu_reset}, 2, "R9 stray write keeps control");
      chk({31'd0, tx_valid}, 0, "R9 stray write no tx effect");
      do_rd(10'h30B, b);
      chk({24'd0, b}, 32'h00, "R9 stray read returns 0");
      do_wr(A_CTL, 8'h00);

      // R8 empty read does not advance phase
      do_rd(A_PORT, b);
      chk({24'd0, b}, 32'h00, "R8 empty read returns 0");
      push_rx(32'h4433_2211);
      do_rd(A_PORT, b);
      chk({24'd0, b}, 32'h11, "R8 first byte after empty read");
      for (int k = 1; k < 4; k++) do_rd(A_PORT, b);
      chk({24'd0, b}, 32'h44, "R8 last byte");

      // R11 interleaved directions
      do_wr(A_PORT, 8'hA0);
      do_wr(A_PORT, 8'hA1);
      push_rx(32'hB3B2_B1B0);
      for (int k = 0; k < 4; k++) begin
         do_rd(A_PORT, b);
         chk({24'd0, b}, {24'd0, 8'hB0 + 8'(k)}, "R11 rx bytes mid transmit");
      end
      do_wr(A_PORT, 8'hA2);
      do_wr(A_PORT, 8'hA3);
      chk(tx_word, 32'hA3A2_A1A0, "R11 tx word after interleave");
      chk({31'd0, tx_valid}, 1, "R11 tx valid after interleave");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule